// File: doc/BRIEF.md
# Channel-Slotted Pulse Delay Merger

This block takes up to sixteen single-bit hit lines and puts every hit onto one shared output line. Each hit is delayed by an amount set for its channel, so a single downstream multi-hit timing channel can time-stamp all the inputs. The arrival order and the known slot offsets then show which channel each output pulse came from. The delay comes from a synchronous recirculating loop in each channel. One loop period is a fixed number of system clocks (15 by default, or 150 ns at 100 MHz), and the channel counts how many times a hit goes round the loop.

Each channel has an 8-bit setting word with two fields. One field is a base delay, normally the same on every channel. The other is the channel's slot number, which must differ between channels. The total delay is (base + slot) loop periods, so neighbouring slots come out one loop period apart. The scheme assumes that hits are rare, so that pulses from different channels seldom coincide on the shared line. Setting words are written through a simple address, data and write-enable port.

Top module: `slot_tdm_merge`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` for channel `cfg_addr` at the clock edge. Bits [7:4] hold the base delay and bits [3:0] hold the slot number. A hit accepted on the same edge as a write still uses the old word. Hits accepted on later edges use the new word.
- R2: A channel accepts a hit at the first clock edge where its input is sampled high after being sampled low at the previous edge, provided the channel is idle. Its `busy` bit is high from that edge on.
- R3: After a hit is accepted at edge k, `merged_out` goes high after edge k + (base+slot)*15 + 2, with 15 clocks per loop period.
- R4: Each delayed hit appears on `merged_out` for exactly one clock cycle. The channel's `busy` bit is already low while that pulse is on the output.
- R5: Rising edges on a busy channel are ignored and do not shift its pending pulse. An input held high never triggers again. A new rising edge after the pulse is accepted normally.
- R6: `merged_out` is the OR of all channel pulses. Channels whose totals are equal produce one merged single-cycle pulse. Channels with distinct totals produce separate pulses at their own times.
- R7: A synchronous active-high `rst` clears every setting word to zero, cancels every pending hit, and drives `busy` and `merged_out` low.
- R8: A channel whose base and slot are both zero produces its pulse 2 edges after the accepting edge.
- R9: The `busy` bits are independent per channel. A hit on one channel raises only that channel's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting-word write enable |
| cfg_addr | input | 4 | Channel selected for the write |
| cfg_wdata | input | 8 | Setting word: [7:4] base, [3:0] slot |
| hit_in | input | 16 | Per-channel hit inputs |
| busy | output | 16 | Per-channel hit-in-flight flags |
| merged_out | output | 1 | Shared line carrying all delayed pulses |

## Verification
The bench sweeps every base value against every channel, with each slot set to its channel number, and measures the output latency to the exact clock. A counter that is off by one loop period, or a loop that reloads wrongly, shows up as a shifted arrival. Further tests cover three more cases. One fires all channels at once and checks the output pattern cycle by cycle. One fires two channels with equal totals, where a design that does not merge them, or that stretches the pulse, gives two highs. One toggles and holds an input during a pending hit, where a design that re-arms early gives an extra or moved pulse. Two timing corners are also probed. A write that lands on the accepting edge must not change the pending delay. A reset during a pending hit must cancel it and zero the settings, so that the next hit arrives at the two-edge minimum.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int FIELD_W = 4;
  localparam int TOTAL_W = FIELD_W + 1;

  typedef struct packed {
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] slot;
  } stm_cfg_t;
endpackage

// File: rtl/stm_cfg_bank.sv
module stm_cfg_bank
  import stm_pkg::*;
#(
  parameter int NCH = 16,
  localparam int AW = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  stm_cfg_t            wdata,
  output stm_cfg_t [NCH-1:0]  cfg_o
);

  stm_cfg_t bank [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) bank[i] <= '0;
    end else if (we && (int'(addr) < NCH)) begin
      bank[addr] <= wdata;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign cfg_o[g] = bank[g];
  end

  // R1: a write is visible in the bank one edge later
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && (int'(addr) < NCH)) |=> (bank[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/stm_chan_delay.sv
module stm_chan_delay
  import stm_pkg::*;
#(
  parameter int LOOP_CLKS = 15,
  localparam int PW = (LOOP_CLKS > 2) ? $clog2(LOOP_CLKS) : 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hit,
  input  stm_cfg_t cfg_i,
  output logic     busy_o,
  output logic     pulse_o
);

  localparam logic [PW-1:0] PH_TOP = PW'(LOOP_CLKS - 1);
  localparam int MAX_LOOPS = 2 * ((1 << FIELD_W) - 1);

  logic               hit_q;
  logic               busy_q;
  logic               pulse_q;
  logic [TOTAL_W-1:0] loops_q;
  logic [PW-1:0]      phase_q;
  logic               accept;

  assign accept = hit && !hit_q && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      loops_q <= '0;
      phase_q <= '0;
    end else begin
      hit_q   <= hit;
      pulse_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        loops_q <= TOTAL_W'(cfg_i.base) + TOTAL_W'(cfg_i.slot);
        phase_q <= PH_TOP;
      end else if (busy_q) begin
        if (loops_q == '0) begin
          busy_q  <= 1'b0;
          pulse_q <= 1'b1;
        end else if (phase_q == '0) begin
          loops_q <= loops_q - 1'b1;
          phase_q <= PH_TOP;
        end else begin
          phase_q <= phase_q - 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign pulse_o = pulse_q;

  // R2: busy only starts from a sampled rising edge
  a_r2_start_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(hit) && !$past(hit_q)));
  // R4: channel pulse is one clock wide
  a_r4_one_clk_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  // R4: channel is idle while its pulse is out
  a_r4_idle_at_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> !busy_q);
  // R5: a pending hit stays pending until its loops run out
  a_r5_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (loops_q != '0)) |=> busy_q);
  // R3: loop count never exceeds the largest programmable total
  a_r3_loops_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (int'(loops_q) <= MAX_LOOPS));

endmodule

// File: rtl/stm_or_merge.sv
module stm_or_merge #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pulses,
  output logic           merged_o
);

  always_ff @(posedge clk) begin
    if (rst) merged_o <= 1'b0;
    else     merged_o <= |pulses;
  end

endmodule

// File: rtl/slot_tdm_merge.sv
module slot_tdm_merge
  import stm_pkg::*;
#(
  parameter int NCH = 16,
  parameter int LOOP_CLKS = 15,
  localparam int AW = $clog2(NCH),
  localparam int WW = 2 * FIELD_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [WW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] hit_in,
  output logic [NCH-1:0] busy,
  output logic           merged_out
);

  stm_cfg_t [NCH-1:0] cfg_w;
  logic [NCH-1:0]     pulse_w;

  stm_cfg_bank #(.NCH(NCH)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (stm_cfg_t'(cfg_wdata)),
    .cfg_o (cfg_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    stm_chan_delay #(.LOOP_CLKS(LOOP_CLKS)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit_in[g]),
      .cfg_i   (cfg_w[g]),
      .busy_o  (busy[g]),
      .pulse_o (pulse_w[g])
    );
  end

  stm_or_merge #(.NCH(NCH)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .pulses   (pulse_w),
    .merged_o (merged_out)
  );

  // R7: nothing is pending or emitted in the cycle after reset
  a_r7_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> ((busy == '0) && !merged_out));

endmodule

// File: tb/test_slot_tdm_merge.sv
module test_slot_tdm_merge;
  localparam int CLK_NS = 10;
  localparam int NCH = 16;
  localparam int LP = 15;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_addr = '0;
  logic [7:0]      cfg_wdata = '0;
  logic [NCH-1:0]  hit_in = '0;
  logic [NCH-1:0]  busy;
  logic            merged_out;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  slot_tdm_merge #(.NCH(NCH), .LOOP_CLKS(LP)) i_slot_tdm_merge (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hit_in(hit_in), .busy(busy), .merged_out(merged_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int b, input int s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(ch); cfg_wdata = {4'(b), 4'(s)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Fires channel ch; expects merged_out high at the negedge after edge tot*LP+3
  task automatic time_hit(input int ch, input int tot, input bit wr_now, input logic [7:0] wd);
    int n = 0;
    bit seen = 0;
    @(negedge clk);
    hit_in[ch] = 1'b1;
    if (wr_now) begin cfg_we = 1'b1; cfg_addr = 4'(ch); cfg_wdata = wd; end
    while (n < 1000 && !seen) begin
      @(posedge clk); n++;
      @(negedge clk);
      cfg_we = 1'b0;
      if (n == 1) check(busy == NCH'(1 << ch), "R2/R9 busy after accept", int'(busy), 1 << ch);
      if (n == 2) hit_in[ch] = 1'b0;
      if (merged_out) seen = 1;
    end
    check(n == tot*LP + 3, "R3 latency", n, tot*LP + 3);
    check(busy[ch] == 1'b0, "R4 busy low at pulse", int'(busy[ch]), 0);
    @(negedge clk);
    check(merged_out == 1'b0, "R4 one-cycle pulse", int'(merged_out), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == '0, "R7 busy in reset", int'(busy), 0);
    check(merged_out == 1'b0, "R7 output in reset", int'(merged_out), 0);
    rst = 1'b0;

    // R7/R8: settings are zero after reset, so minimum delay
    time_hit(0, 0, 0, '0);

    // R3: sweep every base over every channel, slot = channel
    for (int b = 0; b < 16; b++) begin
      for (int c = 0; c < NCH; c++) wr(c, b, c);
      for (int c = 0; c < NCH; c++) time_hit(c, b + c, 0, '0);
    end

    // R6: all channels at once, base 0, slot = channel
    for (int c = 0; c < NCH; c++) wr(c, 0, c);
    @(negedge clk);
    hit_in = '1;
    for (int n = 1; n <= 250; n++) begin
      bit exp;
      @(posedge clk);
      @(negedge clk);
      if (n == 1) check(busy == '1, "R9 all busy", int'(busy), 16'hffff);
      if (n == 2) hit_in = '0;
      exp = (n >= 3) && ((n - 3) % LP == 0) && ((n - 3) / LP < NCH);
      check(merged_out == exp, "R6 distinct slots", int'(merged_out), int'(exp));
    end

    // R6: equal totals merge into one pulse
    wr(0, 1, 2);
    wr(1, 2, 1);
    begin
      int first = -1;
      int highs = 0;
      @(negedge clk);
      hit_in[1:0] = 2'b11;
      for (int n = 1; n <= 100; n++) begin
        @(posedge clk);
        @(negedge clk);
        if (n == 2) hit_in[1:0] = 2'b00;
        if (merged_out) begin highs++; if (first < 0) first = n; end
      end
      check(first == 3*LP + 3, "R6 coincident time", first, 3*LP + 3);
      check(highs == 1, "R6 coincident single pulse", highs, 1);
    end

    // R5: toggles and a held-high input during a pending hit
    wr(2, 2, 3);
    begin
      int first = -1;
      int highs = 0;
      @(negedge clk);
      hit_in[2] = 1'b1;
      for (int n = 1; n <= 5*LP + 150; n++) begin
        @(posedge clk);
        @(negedge clk);
        if (n == 10 || n == 30) hit_in[2] = 1'b0;
        if (n == 15 || n == 31) hit_in[2] = 1'b1;
        if (merged_out) begin highs++; if (first < 0) first = n; end
      end
      check(first == 5*LP + 3, "R5 pulse not moved", first, 5*LP + 3);
      check(highs == 1, "R5 no retrigger", highs, 1);
      hit_in[2] = 1'b0;
      repeat (2) @(negedge clk);
    end
    time_hit(2, 5, 0, '0);  // R5 re-arm

    // R1: write on the accepting edge uses old word; the next hit uses the new one
    wr(3, 4, 4);
    time_hit(3, 8, 1, {4'd1, 4'd1});
    time_hit(3, 2, 0, '0);
    wr(3, 0, 9);
    time_hit(3, 9, 0, '0);  // R1 field positions: [3:0] slot
    wr(3, 7, 0);
    time_hit(3, 7, 0, '0);  // R1 field positions: [7:4] base

    // R7: reset cancels a pending hit and zeroes settings
    wr(4, 15, 15);
    @(negedge clk);
    hit_in[4] = 1'b1;
    repeat (50) @(negedge clk);
    hit_in[4] = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == '0, "R7 busy cleared", int'(busy), 0);
    begin
      int highs = 0;
      for (int n = 0; n < 500; n++) begin
        @(negedge clk);
        if (merged_out) highs++;
      end
      check(highs == 0, "R7 pending hit cancelled", highs, 0);
    end
    time_hit(4, 0, 0, '0);  // R7 settings zeroed, R8 minimum delay

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule